// File: doc/BRIEF.md
# Coherent System Time Reader

This block keeps three independent system time counters, each made of a nanoseconds word and a seconds word, and exposes one of them to software through a small register port. A nanoseconds counter advances by one on every cycle its tick input is high. When its next value would reach a programmable border it returns to zero, and in that same cycle its seconds counter advances by one.

Software reads time as two 32-bit words. Reading the seconds word also stores the nanoseconds word of that same instant. The next nanoseconds read returns the stored value and uses it up, so the two reads always form a consistent pair. A second nanoseconds read with no seconds read between returns the live value again.

A writable seconds-compare register raises a one-cycle event when the selected seconds value becomes equal to it. A 2-bit configuration field chooses which of the three counters is read and compared.

Top module: `sys_time_reader`

## Requirements
- R1: After reset all counters, the compare register, the configuration field, the capture flag and `rdata_o` are zero, and `sec_match_o` is low.
- R2: Each tick of a source raises its nanoseconds count by one. When the raised value would be greater than or equal to `border_i`, the count becomes 0 instead and that source's seconds count rises by one in the same cycle. The border value itself is never visible.
- R3: A read at offset 0x24 returns the selected source's seconds on `rdata_o` in the cycle after the read strobe. It also captures that source's nanoseconds value at the same clock edge.
- R4: The first read at offset 0x28 after a seconds read returns the captured nanoseconds value and clears the capture.
- R5: A read at offset 0x28 with no capture pending returns the selected source's live nanoseconds count.
- R6: Offset 0x2C is a read/write seconds-compare register. `sec_match_o` pulses high for exactly one cycle, one cycle after the selected seconds value becomes equal to it. It does not pulse again while equality holds, and it does not pulse when reset is released.
- R7: Bits [1:0] at offset 0x40 are read/write. Code 0, 1 or 2 selects that source. With code 3, time reads return 0 and no compare event is raised.
- R8: Writes to offsets 0x24 and 0x28 change nothing. Reads of any offset other than 0x24, 0x28, 0x2C and 0x40 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 3 | Per-source count enable, bit k for source k |
| border_i | input | 32 | Nanoseconds wrap border shared by all sources |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_i` |
| sec_match_o | output | 1 | One-cycle seconds-compare event |

## Verification
All read results appear on `rdata_o` one clock after the strobe. The bench raises the strobe at a falling edge and samples the data at the next falling edge. Counter values reflect every tick cycle that has closed. The bench's own model of the counters is advanced once per driven tick cycle, and ticks are held low during reads except where the capture must be told apart from the live value. The compare event lags the seconds change by one register stage. A monitor counts high samples of `sec_match_o` at every falling edge, so an event that lasts two cycles or repeats shows up as a wrong count.

// File: rtl/sys_time_pkg.sv
package sys_time_pkg;
    localparam int NUM_SRC = 3;
    localparam int SEL_W   = 2;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_SEC = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_NS  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_CMP = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_CFG = 8'h40;
endpackage

// File: rtl/systime_counter.sv
module systime_counter #(
    parameter int NS_W = 32,
    parameter int S_W  = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    input  logic [NS_W-1:0] border_i,
    output logic [NS_W-1:0] ns_o,
    output logic [S_W-1:0]  s_o
);
    typedef struct packed {
        logic [NS_W-1:0] ns;
        logic [S_W-1:0]  s;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [NS_W:0] ns_inc;

    always_comb begin
        cnt_d  = cnt_q;
        ns_inc = {1'b0, cnt_q.ns} + 1'b1;
        if (tick_i) begin
            if (ns_inc >= {1'b0, border_i}) begin
                cnt_d.ns = '0;
                cnt_d.s  = cnt_q.s + 1'b1;
            end else begin
                cnt_d.ns = ns_inc[NS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign ns_o = cnt_q.ns;
    assign s_o  = cnt_q.s;

    // R2
    wrap_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q.ns == '0 && $past(cnt_q.ns) != '0) |-> (cnt_q.s == $past(cnt_q.s) + 1'b1));

    // R2
    sec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q.s != $past(cnt_q.s)) |-> (cnt_q.s == $past(cnt_q.s) + 1'b1 && cnt_q.ns == '0));
endmodule

// File: rtl/sec_compare.sv
module sec_compare #(
    parameter int S_W = 32
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           en_i,
    input  logic [S_W-1:0] sec_i,
    input  logic [S_W-1:0] cmp_i,
    output logic           evt_o
);
    typedef struct packed {
        logic eq;
        logic evt;
    } cmp_st_t;

    cmp_st_t st_d, st_q;
    logic    eq_now;

    always_comb begin
        eq_now     = en_i && (sec_i == cmp_i);
        st_d.eq    = eq_now;
        st_d.evt   = eq_now && !st_q.eq;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.eq  <= 1'b1;
            st_q.evt <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;

    // R6
    evt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.evt |=> !st_q.evt);
endmodule

// File: rtl/sys_time_reader.sv
module sys_time_reader
    import sys_time_pkg::*;
#(
    parameter int NS_W = 32,
    parameter int S_W  = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_SRC-1:0]   tick_i,
    input  logic [NS_W-1:0]      border_i,
    input  logic                 rd_i,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 sec_match_o
);
    typedef struct packed {
        logic [NS_W-1:0]   snap;
        logic              snap_vld;
        logic [S_W-1:0]    cmp;
        logic [SEL_W-1:0]  cfg;
        logic [DATA_W-1:0] rdata;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic [NS_W-1:0] ns_w [NUM_SRC];
    logic [S_W-1:0]  s_w  [NUM_SRC];
    logic [NS_W-1:0] sel_ns;
    logic [S_W-1:0]  sel_s;
    logic            sel_ok;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        systime_counter #(.NS_W(NS_W), .S_W(S_W)) u_cnt (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .tick_i   (tick_i[k]),
            .border_i (border_i),
            .ns_o     (ns_w[k]),
            .s_o      (s_w[k])
        );
    end

    always_comb begin
        sel_ok = (int'(st_q.cfg) < NUM_SRC);
        sel_ns = '0;
        sel_s  = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (int'(st_q.cfg) == k) begin
                sel_ns = ns_w[k];
                sel_s  = s_w[k];
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (rd_i) begin
            unique case (addr_i)
                OFS_SEC: begin
                    st_d.rdata    = DATA_W'(sel_s);
                    st_d.snap     = sel_ns;
                    st_d.snap_vld = 1'b1;
                end
                OFS_NS: begin
                    st_d.rdata    = st_q.snap_vld ? DATA_W'(st_q.snap) : DATA_W'(sel_ns);
                    st_d.snap_vld = 1'b0;
                end
                OFS_CMP: st_d.rdata = DATA_W'(st_q.cmp);
                OFS_CFG: st_d.rdata = DATA_W'(st_q.cfg);
                default: st_d.rdata = '0;
            endcase
        end
        if (wr_i) begin
            if (addr_i == OFS_CMP) st_d.cmp = wdata_i[S_W-1:0];
            if (addr_i == OFS_CFG) st_d.cfg = wdata_i[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    sec_compare #(.S_W(S_W)) u_cmp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (sel_ok),
        .sec_i  (sel_s),
        .cmp_i  (st_q.cmp),
        .evt_o  (sec_match_o)
    );

    assign rdata_o = st_q.rdata;

    // R3
    snap_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == OFS_SEC) |=> st_q.snap_vld);

    // R7
    unused_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == OFS_SEC && st_q.cfg == 2'd3) |=> (rdata_o == '0));

    // R8
    cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_i && addr_i == OFS_CMP) |=> $stable(st_q.cmp));
endmodule

// File: tb/sim_sys_time_reader.sv
module sim_sys_time_reader;
    localparam int CLK_PERIOD = 10;
    localparam int BORDER     = 5;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [2:0]  tick_i = '0;
    logic [31:0] border_i = BORDER;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        sec_match_o;

    int n_vec = 0;
    int n_bad = 0;
    int evt_cnt = 0;
    bit done = 0;
    int unsigned m_ns [3];
    int unsigned m_s  [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_ni && sec_match_o) evt_cnt++;

    sys_time_reader u0 (
        .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .border_i(border_i),
        .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .sec_match_o(sec_match_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = mask;
            for (int k = 0; k < 3; k++) begin
                if (mask[k]) begin
                    if (m_ns[k] + 1 >= BORDER) begin
                        m_ns[k] = 0;
                        m_s[k]++;
                    end else begin
                        m_ns[k]++;
                    end
                end
            end
        end
        @(negedge clk);
        tick_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_i = 1'b1; addr_i = a;
        @(negedge clk);
        rd_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 rdata after reset", rdata_o, 32'h0);
        chk("R1 event after reset", {31'b0, sec_match_o}, 32'h0);
        rd(8'h24, d); chk("R1 seconds after reset", d, 32'h0);
        rd(8'h28, d); chk("R1 ns after reset", d, 32'h0);
        rd(8'h2C, d); chk("R1 compare after reset", d, 32'h0);
        rd(8'h40, d); chk("R1 config after reset", d, 32'h0);
        chk("R6 no event out of reset", evt_cnt, 0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        run(3'b001, 4);
        rd(8'h28, d); chk("R2 ns below border", d, m_ns[0]);
        rd(8'h24, d); chk("R2 seconds before wrap", d, 0);
        rd(8'h28, d);
        run(3'b001, 1);
        rd(8'h28, d); chk("R2 ns wraps to zero", d, 32'h0);
        rd(8'h24, d); chk("R2 seconds carry", d, 1);
        rd(8'h28, d);
        run(3'b001, 2);
        rd(8'h28, d); chk("R5 live ns", d, m_ns[0]);
    endtask

    task automatic t_snapshot();
        logic [31:0] d;
        int unsigned held;
        held = m_ns[0];
        rd(8'h24, d); chk("R3 seconds read", d, m_s[0]);
        run(3'b001, 2);
        rd(8'h28, d); chk("R4 captured ns", d, held);
        rd(8'h28, d); chk("R5 second ns read is live", d, m_ns[0]);
    endtask

    task automatic t_select();
        logic [31:0] d;
        run(3'b010, 13);
        run(3'b100, 4);
        wr(8'h40, 32'h1);
        rd(8'h40, d); chk("R7 config readback", d, 32'h1);
        rd(8'h24, d); chk("R7 source 1 seconds", d, m_s[1]);
        rd(8'h28, d); chk("R7 source 1 ns", d, m_ns[1]);
        wr(8'h40, 32'h2);
        rd(8'h24, d); chk("R7 source 2 seconds", d, m_s[2]);
        rd(8'h28, d); chk("R7 source 2 ns", d, m_ns[2]);
        wr(8'h40, 32'h3);
        rd(8'h24, d); chk("R7 code 3 seconds zero", d, 32'h0);
        rd(8'h28, d); chk("R7 code 3 ns zero", d, 32'h0);
        wr(8'h40, 32'h0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_compare();
        logic [31:0] d;
        int unsigned target;
        target = m_s[0] + 1;
        wr(8'h2C, target);
        rd(8'h2C, d); chk("R6 compare readback", d, target);
        evt_cnt = 0;
        run(3'b001, BORDER - m_ns[0]);
        rd(8'h24, d); chk("R6 reached target", d, target);
        repeat (10) @(negedge clk);
        chk("R6 single event pulse", evt_cnt, 1);
        wr(8'h40, 32'h3);
        evt_cnt = 0;
        wr(8'h2C, 32'h0);
        repeat (4) @(negedge clk);
        chk("R7 code 3 raises no event", evt_cnt, 0);
        wr(8'h40, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        int unsigned cmp_before;
        rd(8'h2C, d); cmp_before = d;
        wr(8'h24, 32'hDEAD_BEEF);
        wr(8'h28, 32'h1234_5678);
        rd(8'h24, d); chk("R8 seconds unaffected by write", d, m_s[0]);
        rd(8'h28, d); chk("R8 ns unaffected by write", d, m_ns[0]);
        rd(8'h2C, d); chk("R8 compare unaffected by write", d, cmp_before);
        rd(8'h10, d); chk("R8 unmapped read is zero", d, 32'h0);
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin m_ns[k] = 0; m_s[k] = 0; end
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_snapshot();
        t_select();
        t_compare();
        t_readonly();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule